// File: doc/BRIEF.md
# Map-Reduce Stencil Engine

This block is a convolution-style compute engine. Its data store is a 2D shift register of pixels, 8 rows by 16 columns. Each time the stencil steps down the image, a new row of pixels enters at the bottom and the top row falls off. Every cell of the store is readable at once. A routing stage forms 128 operand pairs from it in parallel: in windowed modes these are eight overlapping 4x4 windows at horizontal offsets 0..7, and in element-wise mode they are the 128 cells one for one. Each pair combines a store cell with an entry of a stationary coefficient store, which holds filter taps, reference-block pixels for SAD, or threshold values. All of this feeds 128 map lanes.

One command is issued per cycle. It names a map operator (absolute difference, multiply, subtract, average or compare) and a reduce operator (add, logical AND or none), together with a stencil height and width of 1 to 4. Its result goes either to a 128-bit output register, one cycle later, or back into the shift register. A row shift and a compute may be issued together, and the compute then sees the store as it was before the shift. A SAD search is the pairing of absolute difference with add over a 4x4 stencil. It yields eight candidate costs per cycle.

Top module: `stencil_engine`

## Requirements
- R1: After reset the shift store, the coefficient store and out_data are all zero, and out_valid is low.
- R2: With shift_en high and no write-back, the store moves up one row: row r takes row r+1, row 7 takes shift_row (column c in bits [8c+7:8c]), and row 0 is discarded.
- R3: coef_we writes coef_row into coefficient row coef_sel. A compute issued in the same cycle uses the coefficients from before the write.
- R4: With op_red not 0, window k (k = 0..7) pairs store cell (row i, column k+j) with coefficient (row i, column j) for i, j in 0..3. Its result appears in out_data[16k+15:16k] in the cycle after op_valid.
- R5: The op_map encodings for an 8-bit pair (a = store, b = coefficient) are: 0 is |a-b|; 1 is (a*b)>>8; 2 is the low 8 bits of a-b; 3 is (a+b+1)>>1; 4 is 1 if a>b, otherwise 0.
- R6: op_red=1 (add) sums the map results of the active lanes, those with i <= op_h and j <= op_w, where the stencil is (op_h+1) rows by (op_w+1) columns. The sum is 16 bits wide and reaches 4080 for a full 4x4 stencil of 255s without overflow.
- R7: op_red=2 (logical AND) gives 1 when every active lane's map result is nonzero, and 0 otherwise.
- R8: op_red=0 (none) with op_dest=0 puts the map result of store row 0, column c against coefficient row 0, column c into out_data[8c+7:8c] for c = 0..15.
- R9: op_dest=1 with a windowed reduce writes min(result_k, 255) into store row 0, column k for k = 0..7. Columns 8..15 stay unchanged. out_valid stays low and out_data holds.
- R10: op_dest=1 with op_red=0 replaces every one of the 128 store cells with its own element-wise map result.
- R11: A compute issued in the same cycle as shift_en uses the store from before the shift. If that compute writes back (op_dest=1), the shift is dropped.
- R12: out_valid is high exactly in the cycle after an op_valid with op_dest=0. In every other cycle out_data keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_en | input | 1 | Shift a new bottom row into the store |
| shift_row | input | 128 | New row, 16 pixels of 8 bits |
| coef_we | input | 1 | Write one coefficient row |
| coef_sel | input | 3 | Coefficient row index |
| coef_row | input | 128 | Coefficient row data, 16 x 8 bits |
| op_valid | input | 1 | Issue a compute |
| op_map | input | 3 | Map operator code (R5) |
| op_red | input | 2 | Reduce operator: 0 none, 1 add, 2 AND |
| op_dest | input | 1 | 0 output register, 1 write back into store |
| op_h | input | 2 | Stencil height minus one |
| op_w | input | 2 | Stencil width minus one |
| out_valid | output | 1 | Output register freshly loaded |
| out_data | output | 128 | Eight 16-bit window results, or sixteen 8-bit element results |

## Verification
The checker assumes that an issued command carries a map code of 0 to 4 and a reduce code of 0 to 2, and that op_valid stays low while reset is asserted. Its bounds on results (at most 1 for AND, at most 4080 for add) only hold for those legal codes. The stimulus picks map and reduce codes only from the legal ranges, and it holds all command inputs at zero until reset is released. It mixes random shifts, coefficient writes and commands with directed saturation, all-ones and write-back sequences.

// File: rtl/stencil_engine_pkg.sv
package stencil_engine_pkg;

    typedef enum logic [2:0] {
        MAP_ABSDIFF = 3'd0,
        MAP_MUL     = 3'd1,
        MAP_SUB     = 3'd2,
        MAP_AVG     = 3'd3,
        MAP_CMP     = 3'd4
    } map_op_e;

    typedef enum logic [1:0] {
        RED_NONE = 2'd0,
        RED_ADD  = 2'd1,
        RED_AND  = 2'd2
    } red_op_e;

    typedef enum logic {
        DEST_OUT   = 1'b0,
        DEST_STORE = 1'b1
    } dest_e;

endpackage

// File: rtl/se_map_lane.sv
module se_map_lane
    import stencil_engine_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] a,
    input  logic [PIX_W-1:0] b,
    input  map_op_e          op,
    output logic [PIX_W-1:0] y
);

    logic [2*PIX_W-1:0] prod;
    logic [PIX_W:0]     sum_rnd;

    assign prod    = {{PIX_W{1'b0}}, a} * {{PIX_W{1'b0}}, b};
    assign sum_rnd = {1'b0, a} + {1'b0, b} + {{PIX_W{1'b0}}, 1'b1};

    always_comb begin
        unique case (op)
            MAP_ABSDIFF: y = (a > b) ? (a - b) : (b - a);
            MAP_MUL:     y = prod[2*PIX_W-1:PIX_W];
            MAP_SUB:     y = a - b;
            MAP_AVG:     y = sum_rnd[PIX_W:1];
            MAP_CMP:     y = {{(PIX_W-1){1'b0}}, (a > b)};
            default:     y = '0;
        endcase
    end

endmodule

// File: rtl/se_window_reduce.sv
module se_window_reduce
    import stencil_engine_pkg::*;
#(
    parameter int WIN   = 4,
    parameter int PIX_W = 8,
    parameter int ACC_W = 16
) (
    input  logic [WIN*WIN*PIX_W-1:0] lanes,
    input  logic [$clog2(WIN)-1:0]   h_m1,
    input  logic [$clog2(WIN)-1:0]   w_m1,
    input  red_op_e                  red,
    output logic [ACC_W-1:0]         res
);

    logic [ACC_W-1:0] acc;
    logic             all_set;

    always_comb begin
        acc     = '0;
        all_set = 1'b1;
        for (int i = 0; i < WIN; i++) begin
            for (int j = 0; j < WIN; j++) begin
                if (i <= int'(h_m1) && j <= int'(w_m1)) begin
                    acc = acc + ACC_W'(lanes[(i*WIN+j)*PIX_W +: PIX_W]);
                    if (lanes[(i*WIN+j)*PIX_W +: PIX_W] == '0) begin
                        all_set = 1'b0;
                    end
                end
            end
        end
    end

    always_comb begin
        unique case (red)
            RED_ADD: res = acc;
            RED_AND: res = ACC_W'(all_set);
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/se_shift_array.sv
module se_shift_array #(
    parameter int ROWS  = 8,
    parameter int COLS  = 16,
    parameter int PIX_W = 8,
    parameter int HEAD  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       shift_en,
    input  logic [COLS*PIX_W-1:0]      row_in,
    input  logic                       wb_all_en,
    input  logic [ROWS*COLS*PIX_W-1:0] wb_all_data,
    input  logic                       wb_head_en,
    input  logic [HEAD*PIX_W-1:0]      wb_head_data,
    output logic [ROWS*COLS*PIX_W-1:0] cells
);

    logic [PIX_W-1:0] mem [ROWS][COLS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    mem[r][c] <= '0;
                end
            end
        end else if (wb_all_en) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    mem[r][c] <= wb_all_data[(r*COLS+c)*PIX_W +: PIX_W];
                end
            end
        end else if (wb_head_en) begin
            for (int c = 0; c < HEAD; c++) begin
                mem[0][c] <= wb_head_data[c*PIX_W +: PIX_W];
            end
        end else if (shift_en) begin
            for (int r = 0; r < ROWS-1; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    mem[r][c] <= mem[r+1][c];
                end
            end
            for (int c = 0; c < COLS; c++) begin
                mem[ROWS-1][c] <= row_in[c*PIX_W +: PIX_W];
            end
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            assign cells[(r*COLS+c)*PIX_W +: PIX_W] = mem[r][c];
        end
    end

endmodule

// File: rtl/se_coef_store.sv
module se_coef_store #(
    parameter int ROWS  = 8,
    parameter int COLS  = 16,
    parameter int PIX_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [$clog2(ROWS)-1:0]    sel,
    input  logic [COLS*PIX_W-1:0]      row_in,
    output logic [ROWS*COLS*PIX_W-1:0] cells
);

    logic [PIX_W-1:0] mem [ROWS][COLS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    mem[r][c] <= '0;
                end
            end
        end else if (we) begin
            for (int c = 0; c < COLS; c++) begin
                mem[sel][c] <= row_in[c*PIX_W +: PIX_W];
            end
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            assign cells[(r*COLS+c)*PIX_W +: PIX_W] = mem[r][c];
        end
    end

endmodule

// File: rtl/stencil_engine.sv
module stencil_engine
    import stencil_engine_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int COLS  = 16,
    parameter int PIX_W = 8,
    parameter int WIN   = 4,
    parameter int NWIN  = 8,
    parameter int ACC_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift_en,
    input  logic [COLS*PIX_W-1:0]    shift_row,
    input  logic                     coef_we,
    input  logic [$clog2(ROWS)-1:0]  coef_sel,
    input  logic [COLS*PIX_W-1:0]    coef_row,
    input  logic                     op_valid,
    input  logic [2:0]               op_map,
    input  logic [1:0]               op_red,
    input  logic                     op_dest,
    input  logic [$clog2(WIN)-1:0]   op_h,
    input  logic [$clog2(WIN)-1:0]   op_w,
    output logic                     out_valid,
    output logic [COLS*PIX_W-1:0]    out_data
);

    localparam int LANES  = ROWS * COLS;
    localparam int WLANES = WIN * WIN;
    localparam int ROW_W  = COLS * PIX_W;
    localparam int ALL_W  = LANES * PIX_W;
    localparam int RES_W  = NWIN * ACC_W;
    localparam int PIX_MAX = (1 << PIX_W) - 1;

    map_op_e map_op;
    red_op_e red_op;
    dest_e   dest;
    logic    win_mode;
    logic    to_out;
    logic    to_store;

    assign map_op   = map_op_e'(op_map);
    assign red_op   = red_op_e'(op_red);
    assign dest     = dest_e'(op_dest);
    assign win_mode = (red_op != RED_NONE);
    assign to_out   = op_valid && (dest == DEST_OUT);
    assign to_store = op_valid && (dest == DEST_STORE);

    logic [ALL_W-1:0]       sr_cells;
    logic [ALL_W-1:0]       cf_cells;
    logic [ALL_W-1:0]       lane_a;
    logic [ALL_W-1:0]       lane_b;
    logic [ALL_W-1:0]       lane_y;
    logic [RES_W-1:0]       win_res;
    logic [NWIN*PIX_W-1:0]  head_data;
    logic [ROW_W-1:0]       out_next;

    se_shift_array #(
        .ROWS(ROWS), .COLS(COLS), .PIX_W(PIX_W), .HEAD(NWIN)
    ) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .shift_en     (shift_en),
        .row_in       (shift_row),
        .wb_all_en    (to_store && !win_mode),
        .wb_all_data  (lane_y),
        .wb_head_en   (to_store && win_mode),
        .wb_head_data (head_data),
        .cells        (sr_cells)
    );

    se_coef_store #(
        .ROWS(ROWS), .COLS(COLS), .PIX_W(PIX_W)
    ) u_coef (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (coef_we),
        .sel    (coef_sel),
        .row_in (coef_row),
        .cells  (cf_cells)
    );

    // Operand routing: each lane picks a window tap or its own cell.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int KW   = l / WLANES;
        localparam int WI   = (l % WLANES) / WIN;
        localparam int WJ   = l % WIN;
        localparam int SR_W = (WI*COLS + KW + WJ) * PIX_W;
        localparam int CF_W = (WI*COLS + WJ) * PIX_W;

        assign lane_a[l*PIX_W +: PIX_W] = win_mode ? sr_cells[SR_W +: PIX_W]
                                                   : sr_cells[l*PIX_W +: PIX_W];
        assign lane_b[l*PIX_W +: PIX_W] = win_mode ? cf_cells[CF_W +: PIX_W]
                                                   : cf_cells[l*PIX_W +: PIX_W];

        se_map_lane #(.PIX_W(PIX_W)) u_map (
            .a  (lane_a[l*PIX_W +: PIX_W]),
            .b  (lane_b[l*PIX_W +: PIX_W]),
            .op (map_op),
            .y  (lane_y[l*PIX_W +: PIX_W])
        );
    end

    for (genvar k = 0; k < NWIN; k++) begin : g_win
        se_window_reduce #(
            .WIN(WIN), .PIX_W(PIX_W), .ACC_W(ACC_W)
        ) u_red (
            .lanes (lane_y[k*WLANES*PIX_W +: WLANES*PIX_W]),
            .h_m1  (op_h),
            .w_m1  (op_w),
            .red   (red_op),
            .res   (win_res[k*ACC_W +: ACC_W])
        );

        assign head_data[k*PIX_W +: PIX_W] =
            (win_res[k*ACC_W +: ACC_W] > ACC_W'(PIX_MAX)) ? {PIX_W{1'b1}}
                                                          : win_res[k*ACC_W +: PIX_W];
    end

    assign out_next = win_mode ? win_res : lane_y[ROW_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= to_out;
            if (to_out) begin
                out_data <= out_next;
            end
        end
    end

endmodule

// File: rtl/stencil_engine_chk.sv
module stencil_engine_chk #(
    parameter int WIN   = 4,
    parameter int PIX_W = 8,
    parameter int NWIN  = 8,
    parameter int ACC_W = 16,
    parameter int OUT_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [2:0]       op_map,
    input logic [1:0]       op_red,
    input logic             op_dest,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data
);

    localparam int MAXSUM = WIN * WIN * ((1 << PIX_W) - 1);

    // R5
    op_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> (op_map <= 3'd4 && op_red != 2'd3));

    // R12
    out_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(op_valid && !op_dest));

    // R12
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && !op_dest) |=> (!out_valid && $stable(out_data)));

    for (genvar k = 0; k < NWIN; k++) begin : g_field
        // R7
        and_binary_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && !op_dest && op_red == 2'd2)
                |=> (out_data[k*ACC_W +: ACC_W] <= ACC_W'(1)));

        // R6
        no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && !op_dest && op_red == 2'd1)
                |=> (out_data[k*ACC_W +: ACC_W] <= ACC_W'(MAXSUM)));
    end

endmodule

bind stencil_engine stencil_engine_chk #(
    .WIN(WIN), .PIX_W(PIX_W), .NWIN(NWIN), .ACC_W(ACC_W), .OUT_W(COLS*PIX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_map    (op_map),
    .op_red    (op_red),
    .op_dest   (op_dest),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/stencil_engine_tb.sv
module stencil_engine_tb;

    localparam int PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         shift_en;
    logic [127:0] shift_row;
    logic         coef_we;
    logic [2:0]   coef_sel;
    logic [127:0] coef_row;
    logic         op_valid;
    logic [2:0]   op_map;
    logic [1:0]   op_red;
    logic         op_dest;
    logic [1:0]   op_h;
    logic [1:0]   op_w;
    logic         out_valid;
    logic [127:0] out_data;

    always #(PERIOD/2) clk = ~clk;

    stencil_engine u_dut (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .shift_row(shift_row),
        .coef_we(coef_we), .coef_sel(coef_sel), .coef_row(coef_row),
        .op_valid(op_valid), .op_map(op_map), .op_red(op_red), .op_dest(op_dest),
        .op_h(op_h), .op_w(op_w), .out_valid(out_valid), .out_data(out_data)
    );

    int           sr [8][16];
    int           cf [8][16];
    logic [127:0] exp_out;
    int           n_chk = 0;
    int           n_fail = 0;

    function automatic int mapf(int a, int b, int m);
        case (m)
            0:       return (a > b) ? a - b : b - a;
            1:       return (a * b) >> 8;
            2:       return (a - b) & 255;
            3:       return (a + b + 1) >> 1;
            default: return (a > b) ? 1 : 0;
        endcase
    endfunction

    function automatic logic [127:0] rand_row();
        logic [127:0] v;
        for (int c = 0; c < 16; c++) v[8*c +: 8] = 8'($urandom_range(0, 255));
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step(input bit sh, input logic [127:0] srow,
                        input bit cw, input int csel, input logic [127:0] crow,
                        input bit ov, input int mp, input int rd, input bit dst,
                        input int h, input int w, input string tag);
        int           res [8];
        int           nxt [8][16];
        logic [127:0] e;
        shift_en  = sh;
        shift_row = srow;
        coef_we   = cw;
        coef_sel  = 3'(csel);
        coef_row  = crow;
        op_valid  = ov;
        op_map    = 3'(mp);
        op_red    = 2'(rd);
        op_dest   = dst;
        op_h      = 2'(h - 1);
        op_w      = 2'(w - 1);
        // Expected values from the pre-edge model state (R3, R11)
        for (int k = 0; k < 8; k++) begin
            int acc = 0;
            int ok  = 1;
            for (int i = 0; i < h; i++) begin
                for (int j = 0; j < w; j++) begin
                    int v = mapf(sr[i][k+j], cf[i][j], mp);
                    acc += v;
                    if (v == 0) ok = 0;
                end
            end
            res[k] = (rd == 1) ? acc : ok;
        end
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 16; c++)
                nxt[r][c] = mapf(sr[r][c], cf[r][c], mp);
        e = exp_out;
        if (ov && !dst) begin
            if (rd != 0) for (int k = 0; k < 8; k++) e[16*k +: 16] = 16'(res[k]);
            else         for (int c = 0; c < 16; c++) e[8*c +: 8] = 8'(nxt[0][c]);
        end
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == (ov && !dst), "R12", {127'b0, out_valid}, {127'b0, (ov && !dst)});
        chk(out_data == e, tag, out_data, e);
        exp_out = e;
        // Model update
        if (ov && dst) begin
            if (rd != 0) begin
                for (int k = 0; k < 8; k++) sr[0][k] = (res[k] > 255) ? 255 : res[k];
            end else begin
                for (int r = 0; r < 8; r++)
                    for (int c = 0; c < 16; c++) sr[r][c] = nxt[r][c];
            end
        end else if (sh) begin
            for (int r = 0; r < 7; r++)
                for (int c = 0; c < 16; c++) sr[r][c] = sr[r+1][c];
            for (int c = 0; c < 16; c++) sr[7][c] = int'(srow[8*c +: 8]);
        end
        if (cw) for (int c = 0; c < 16; c++) cf[csel][c] = int'(crow[8*c +: 8]);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R12 act=hung exp=finished");
        summary();
        $finish;
    end

    initial begin
        logic [127:0] ff_row;
        logic [127:0] one_cf;
        void'($urandom(32'd4242));
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 16; c++) begin sr[r][c] = 0; cf[r][c] = 0; end
        exp_out = '0;
        rst_n = 1'b0;
        shift_en = 0; shift_row = '0; coef_we = 0; coef_sel = '0; coef_row = '0;
        op_valid = 0; op_map = '0; op_red = '0; op_dest = 0; op_h = '0; op_w = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(out_valid == 1'b0, "R1", {127'b0, out_valid}, '0);
        chk(out_data == '0, "R1", out_data, '0);
        step(0, '0, 0, 0, '0, 1, 0, 0, 0, 1, 1, "R1");
        step(0, '0, 0, 0, '0, 1, 1, 1, 0, 4, 4, "R1");

        // R3 coefficient rows, last write alongside a compute
        for (int r = 0; r < 4; r++) step(0, '0, 1, r, rand_row(), 0, 0, 0, 0, 1, 1, "R3");
        step(0, '0, 1, 0, rand_row(), 1, 0, 1, 0, 4, 4, "R3");
        step(0, '0, 0, 0, '0, 1, 0, 0, 0, 1, 1, "R3");

        // R2 row shifting, observed through element-wise readback
        for (int n = 0; n < 8; n++) begin
            step(1, rand_row(), 0, 0, '0, 0, 0, 0, 0, 1, 1, "R2");
            step(0, '0, 0, 0, '0, 1, 0, 0, 0, 1, 1, "R2");
        end

        // R4 R6 SAD windows, full and partial stencils
        step(0, '0, 0, 0, '0, 1, 0, 1, 0, 4, 4, "R4 R6");
        step(0, '0, 0, 0, '0, 1, 0, 1, 0, 2, 3, "R4 R6");
        step(0, '0, 0, 0, '0, 1, 0, 1, 0, 1, 4, "R4 R6");

        // R5 every map code, reduced and element-wise
        for (int m = 0; m < 5; m++) begin
            step(0, '0, 0, 0, '0, 1, m, 1, 0, 4, 4, "R5");
            step(0, '0, 0, 0, '0, 1, m, 2, 0, 3, 2, "R5");
            step(0, '0, 0, 0, '0, 1, m, 0, 0, 1, 1, "R5");
        end

        // R8 element-wise output row
        step(0, '0, 0, 0, '0, 1, 3, 0, 0, 1, 1, "R8");

        // R6 largest sum: store all 255, coefficients zero
        ff_row = '1;
        for (int r = 0; r < 8; r++) step(0, '0, 1, r, '0, 0, 0, 0, 0, 1, 1, "R6");
        for (int n = 0; n < 8; n++) step(1, ff_row, 0, 0, '0, 0, 0, 0, 0, 1, 1, "R6");
        step(0, '0, 0, 0, '0, 1, 0, 1, 0, 4, 4, "R6");

        // R7 compare with AND: all true, then one lane false
        step(0, '0, 0, 0, '0, 1, 4, 2, 0, 4, 4, "R7");
        one_cf = '0;
        one_cf[8*2 +: 8] = 8'hFF;
        step(0, '0, 1, 1, one_cf, 0, 0, 0, 0, 1, 1, "R7");
        step(0, '0, 0, 0, '0, 1, 4, 2, 0, 4, 4, "R7");
        step(0, '0, 0, 0, '0, 1, 4, 2, 0, 1, 4, "R7");
        step(0, '0, 0, 0, '0, 1, 4, 2, 0, 2, 2, "R7");

        // R9 windowed write-back saturates, then readback
        step(0, '0, 0, 0, '0, 1, 0, 1, 1, 4, 4, "R9");
        step(0, '0, 0, 0, '0, 1, 0, 0, 0, 1, 1, "R9");
        step(0, '0, 1, 0, rand_row(), 0, 0, 0, 0, 1, 1, "R9");
        step(0, '0, 0, 0, '0, 1, 2, 1, 1, 1, 1, "R9");
        step(0, '0, 0, 0, '0, 1, 0, 0, 0, 1, 1, "R9");

        // R10 element-wise write-back of all cells, then readback by shifting
        step(0, '0, 0, 0, '0, 1, 3, 0, 1, 1, 1, "R10");
        for (int n = 0; n < 8; n++) begin
            step(0, '0, 0, 0, '0, 1, 0, 0, 0, 1, 1, "R10");
            step(1, rand_row(), 0, 0, '0, 0, 0, 0, 0, 1, 1, "R10");
        end

        // R11 shift together with compute; write-back drops the shift
        step(1, rand_row(), 0, 0, '0, 1, 0, 1, 0, 4, 4, "R11");
        step(1, rand_row(), 0, 0, '0, 1, 0, 0, 0, 1, 1, "R11");
        step(1, rand_row(), 0, 0, '0, 1, 1, 0, 1, 1, 1, "R11");
        step(0, '0, 0, 0, '0, 1, 0, 0, 0, 1, 1, "R11");
        step(1, rand_row(), 0, 0, '0, 1, 0, 1, 1, 3, 3, "R11");
        step(0, '0, 0, 0, '0, 1, 0, 1, 0, 4, 4, "R11");

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            int    rd = $urandom_range(0, 2);
            string tg = (rd == 1) ? "R6" : (rd == 2) ? "R7" : "R8";
            step(($urandom_range(0, 2) == 0), rand_row(),
                 ($urandom_range(0, 3) == 0), $urandom_range(0, 7), rand_row(),
                 ($urandom_range(0, 2) != 0), $urandom_range(0, 4), rd,
                 ($urandom_range(0, 4) == 0), $urandom_range(1, 4),
                 $urandom_range(1, 4), tg);
        end

        op_valid = 0; shift_en = 0; coef_we = 0;
        summary();
        $finish;
    end

endmodule